// File: doc/BRIEF.md
# Slave Address Match and Wake-Up Unit

This block sits beside the shift engine of a serial-bus slave. Software programs an 8-bit station address. When the engine reports a completed byte during the address phase, the block compares that byte with the station address. It can leave the least significant bit out of the comparison. The result is held as a match flag until the next address phase begins. An address that does not match also clears the bus-release flag, which is set whenever the bus signalling logic reports a release.

The block also decides when the transfer-complete interrupt fires, using one of three policies:
- By default every completed byte raises the interrupt.
- In wake-up mode only a matching address raises it, so a sleeping slave is disturbed only when it is addressed.
- A higher-priority control bit makes bus release the interrupt source and disables wake-up gating.

Finally, when the device drives a byte onto the line, that byte can be loaded for comparison. A transmit error is flagged if the byte read back at frame completion differs from it.

Top module: `slave_addr_match`

## Requirements
- R1: The station address register resets to 0x00 and takes `sa_wr_data` on a cycle with `sa_wr_en` high. A compare in that same cycle still uses the old value.
- R2: With `mask_lsb` low, a cycle with `frame_done` and `addr_phase` both high sets `match` one cycle later to 1 if `rx_byte` equals the station address in all 8 bits, and to 0 otherwise.
- R3: With `mask_lsb` high, bit 0 takes no part in the compare, and only bits 7..1 must be equal for `match` to be set.
- R4: `match` keeps its value across `frame_done` strobes outside the address phase. It clears one cycle after `addr_phase` rises, unless that same cycle is an address-phase frame completion, in which case the compare result is loaded instead.
- R5: `release_det` sets `rel_flag` one cycle later. An address-phase frame completion that does not match clears it one cycle later. If both happen in the same cycle, the set wins.
- R6: With `wake_en` and `irq_on_release` both low, each `frame_done` cycle produces exactly a one-cycle `irq` pulse in the following cycle.
- R7: With `wake_en` high and `irq_on_release` low, `irq` pulses one cycle after an address-phase frame completion that matches, and stays low otherwise.
- R8: With `irq_on_release` high, `irq` in each cycle equals `release_det` of the previous cycle, whatever `wake_en` and `frame_done` are.
- R9: `tx_load` captures `tx_byte`, arms the error check and clears `tx_err`. The next `frame_done` sets `tx_err` to 1 if `rx_byte` differs from the captured byte, sets it to 0 otherwise, and disarms the check. An unarmed `frame_done` leaves `tx_err` unchanged. `tx_load` takes priority over `frame_done` in the same cycle.
- R10: While `rst_n` is low at a clock edge, `match`, `rel_flag`, `irq` and `tx_err` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sa_wr_en | input | 1 | Write strobe for the station address |
| sa_wr_data | input | 8 | Station address value to write |
| mask_lsb | input | 1 | Leave bit 0 out of the address compare |
| wake_en | input | 1 | Interrupt only on matching address |
| irq_on_release | input | 1 | Interrupt on bus release; overrides wake-up |
| addr_phase | input | 1 | High while the current byte is an address |
| frame_done | input | 1 | One-cycle strobe: a byte has completed |
| release_det | input | 1 | One-cycle strobe: bus release seen |
| rx_byte | input | 8 | Byte assembled from the line |
| tx_load | input | 1 | Capture `tx_byte` for read-back checking |
| tx_byte | input | 8 | Byte this device is driving |
| match | output | 1 | Address matched |
| rel_flag | output | 1 | Bus-release flag |
| irq | output | 1 | Transfer-complete interrupt request |
| tx_err | output | 1 | Read-back differed from the driven byte |

## Verification
The hardest situations to reach are collisions of events in one cycle. Examples are an address-phase completion landing on the very cycle `addr_phase` rises, `release_det` arriving together with a mismatching address, and `tx_load` arriving together with `frame_done`. Purely random bytes almost never match the station address. The stimulus therefore biases `rx_byte` to equal the address, or to differ from it only in bit 0, about half the time. It holds each mode for a few hundred cycles, drives the strobes independently so that collisions occur regularly, and adds directed sequences for each collision.

// File: rtl/sam_pkg.sv
// Shared types and sizes for the slave address match unit.
// Assumes a byte-wide serial bus; the width stays a parameter for reuse.
package sam_pkg;
    localparam int BYTE_W = 8;

    // Interrupt policy bits, grouped so the gate sees one value.
    typedef struct packed {
        logic irq_on_release;
        logic wake_en;
    } sam_irq_ctrl_t;
endpackage

// File: rtl/sam_addr_reg.sv
// Station address register.
// Assumes writes come from a register-write strobe in the clock domain.
// A write takes effect at the clock edge, so a compare in the same cycle sees the old value.
module sam_addr_reg #(
    parameter int W = sam_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] addr_q
);
    // Hold the programmed address; reset to all zeros.
    always_ff @(posedge clk) begin
        if (!rst_n)     addr_q <= '0;
        else if (wr_en) addr_q <= wr_data;
    end

    assert_addr_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> addr_q == $past(wr_data));
endmodule

// File: rtl/sam_addr_cmp.sv
// Combinational address comparator with an optional masked LSB.
// Assumes both operands are stable for the cycle of the frame strobe.
module sam_addr_cmp #(
    parameter int W = sam_pkg::BYTE_W
) (
    input  logic [W-1:0] rx_byte,
    input  logic [W-1:0] addr_q,
    input  logic         mask_lsb,
    output logic         hit
);
    logic [W-1:0] diff;

    // Per-bit difference; bit 0 is dropped when masking is requested.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign diff[i] = (rx_byte[i] ^ addr_q[i]) & ~mask_lsb;
        end else begin : g_upper
            assign diff[i] = rx_byte[i] ^ addr_q[i];
        end
    end

    // A hit means no bit taking part in the compare differs.
    always_comb hit = ~|diff;
endmodule

// File: rtl/sam_match_track.sv
// Match flag and bus-release flag tracking.
// Assumes frame_done and release_det are single-cycle strobes and that
// addr_phase is a level held for the whole address byte.
module sam_match_track (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_phase,
    input  logic frame_done,
    input  logic release_det,
    input  logic hit,
    output logic match,
    output logic rel_flag
);
    logic ap_q;
    logic addr_ev;
    logic ap_rise;

    // Decode address completion and the start of a new address phase.
    always_comb begin
        addr_ev = frame_done & addr_phase;
        ap_rise = addr_phase & ~ap_q;
    end

    // Remember the previous address-phase level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ap_q <= 1'b0;
        else        ap_q <= addr_phase;
    end

    // Load the compare result on address completion; clear on a new phase.
    always_ff @(posedge clk) begin
        if (!rst_n)       match <= 1'b0;
        else if (addr_ev) match <= hit;
        else if (ap_rise) match <= 1'b0;
    end

    // Set on bus release; clear on a mismatching address (the set wins).
    always_ff @(posedge clk) begin
        if (!rst_n)                rel_flag <= 1'b0;
        else if (release_det)      rel_flag <= 1'b1;
        else if (addr_ev && !hit)  rel_flag <= 1'b0;
    end

    assert_match_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && addr_phase && hit) |=> match);
    assert_match_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_phase && !(ap_q == 1'b0 && addr_phase)) |=> $stable(match));
    assert_match_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && !ap_q && !frame_done) |=> !match);
    assert_rel_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        release_det |=> rel_flag);
    assert_rel_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && addr_phase && !hit && !release_det) |=> !rel_flag);
endmodule

// File: rtl/sam_irq_gate.sv
// Interrupt source selection and wake-up gating.
// Assumes all event inputs are single-cycle strobes; output is a registered pulse.
module sam_irq_gate (
    input  logic                   clk,
    input  logic                   rst_n,
    input  sam_pkg::sam_irq_ctrl_t ctrl,
    input  logic                   addr_phase,
    input  logic                   frame_done,
    input  logic                   release_det,
    input  logic                   hit,
    output logic                   irq
);
    logic irq_d;

    // Pick the source: release beats wake-up, which beats every frame.
    always_comb begin
        if (ctrl.irq_on_release)  irq_d = release_det;
        else if (ctrl.wake_en)    irq_d = frame_done & addr_phase & hit;
        else                      irq_d = frame_done;
    end

    // Register the request so it is a clean one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= irq_d;
    end

    assert_irq_every_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.irq_on_release && !ctrl.wake_en && frame_done) |=> irq);
    assert_irq_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.wake_en && !ctrl.irq_on_release && !(frame_done && addr_phase)) |=> !irq);
    assert_irq_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.irq_on_release |=> irq == $past(release_det));
endmodule

// File: rtl/sam_tx_check.sv
// Read-back error check for bytes this device drives onto the line.
// Assumes tx_load comes before the frame whose read-back it checks.
module sam_tx_check #(
    parameter int W = sam_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_load,
    input  logic [W-1:0] tx_byte,
    input  logic         frame_done,
    input  logic [W-1:0] rx_byte,
    output logic         tx_err
);
    logic [W-1:0] sent_q;
    logic         armed_q;

    // Capture the driven byte and arm; disarm on the checked frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_q  <= '0;
            armed_q <= 1'b0;
        end else if (tx_load) begin
            sent_q  <= tx_byte;
            armed_q <= 1'b1;
        end else if (frame_done) begin
            armed_q <= 1'b0;
        end
    end

    // Clear on load; on an armed frame report whether the read-back differs.
    always_ff @(posedge clk) begin
        if (!rst_n)                      tx_err <= 1'b0;
        else if (tx_load)                tx_err <= 1'b0;
        else if (frame_done && armed_q)  tx_err <= (rx_byte != sent_q);
    end

    assert_err_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_err);
    assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_load && !(frame_done && armed_q)) |=> $stable(tx_err));
endmodule

// File: rtl/slave_addr_match.sv
// Slave address match and wake-up unit: top level.
// Assumes strobes come from a shift engine and bus monitor in the same clock domain.
// Integrates the address register, comparator, flag tracking, interrupt gate and
// transmit read-back check.
module slave_addr_match #(
    parameter int W = sam_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sa_wr_en,
    input  logic [W-1:0] sa_wr_data,
    input  logic         mask_lsb,
    input  logic         wake_en,
    input  logic         irq_on_release,
    input  logic         addr_phase,
    input  logic         frame_done,
    input  logic         release_det,
    input  logic [W-1:0] rx_byte,
    input  logic         tx_load,
    input  logic [W-1:0] tx_byte,
    output logic         match,
    output logic         rel_flag,
    output logic         irq,
    output logic         tx_err
);
    logic [W-1:0]           addr_q;
    logic                   hit;
    sam_pkg::sam_irq_ctrl_t irq_ctrl;

    // Bundle the interrupt policy bits.
    always_comb begin
        irq_ctrl.irq_on_release = irq_on_release;
        irq_ctrl.wake_en        = wake_en;
    end

    sam_addr_reg #(.W(W)) u_addr (
        .clk(clk), .rst_n(rst_n), .wr_en(sa_wr_en), .wr_data(sa_wr_data),
        .addr_q(addr_q));

    sam_addr_cmp #(.W(W)) u_cmp (
        .rx_byte(rx_byte), .addr_q(addr_q), .mask_lsb(mask_lsb), .hit(hit));

    sam_match_track u_track (
        .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase),
        .frame_done(frame_done), .release_det(release_det), .hit(hit),
        .match(match), .rel_flag(rel_flag));

    sam_irq_gate u_irq (
        .clk(clk), .rst_n(rst_n), .ctrl(irq_ctrl), .addr_phase(addr_phase),
        .frame_done(frame_done), .release_det(release_det), .hit(hit),
        .irq(irq));

    sam_tx_check #(.W(W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_byte(tx_byte),
        .frame_done(frame_done), .rx_byte(rx_byte), .tx_err(tx_err));

    assert_masked_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_lsb && frame_done && addr_phase && rx_byte[W-1:1] == addr_q[W-1:1])
        |=> match);
    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (!match && !rel_flag && !irq && !tx_err));
endmodule

// File: tb/slave_addr_match_test.sv
// Self-checking bench: random stimulus plus directed collisions, checked
// against a cycle model written from the requirements.
module slave_addr_match_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sa_wr_en, mask_lsb, wake_en, irq_on_release;
    logic       addr_phase, frame_done, release_det, tx_load;
    logic [7:0] sa_wr_data, rx_byte, tx_byte;
    logic       match, rel_flag, irq, tx_err;

    int checks = 0;
    int fails  = 0;

    // Model state.
    logic [7:0] m_sa, m_sent;
    logic       m_apq, m_match, m_rel, m_irq, m_err, m_armed;

    always #5 clk = ~clk;

    slave_addr_match uut (
        .clk(clk), .rst_n(rst_n), .sa_wr_en(sa_wr_en), .sa_wr_data(sa_wr_data),
        .mask_lsb(mask_lsb), .wake_en(wake_en), .irq_on_release(irq_on_release),
        .addr_phase(addr_phase), .frame_done(frame_done), .release_det(release_det),
        .rx_byte(rx_byte), .tx_load(tx_load), .tx_byte(tx_byte),
        .match(match), .rel_flag(rel_flag), .irq(irq), .tx_err(tx_err));

    function automatic logic exp_hit(logic [7:0] rx, logic [7:0] sa, logic msk);
        return msk ? (rx[7:1] == sa[7:1]) : (rx == sa);
    endfunction

    function automatic logic exp_irq(logic ior, logic wk, logic fd, logic ap,
                                     logic rd, logic h);
        if (ior)     return rd;
        else if (wk) return fd & ap & h;
        else         return fd;
    endfunction

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_sa = 8'h00; m_sent = 8'h00; m_apq = 0; m_match = 0;
        m_rel = 0; m_irq = 0; m_err = 0; m_armed = 0;
    endtask

    // Advance the model by one edge using the inputs now on the pins.
    task automatic model_step();
        logic h, ev, rise;
        h    = exp_hit(rx_byte, m_sa, mask_lsb);
        ev   = frame_done & addr_phase;
        rise = addr_phase & ~m_apq;
        m_irq = exp_irq(irq_on_release, wake_en, frame_done, addr_phase, release_det, h);
        if (ev)        m_match = h;
        else if (rise) m_match = 1'b0;
        if (release_det)   m_rel = 1'b1;
        else if (ev && !h) m_rel = 1'b0;
        if (tx_load) begin
            m_err = 1'b0; m_sent = tx_byte; m_armed = 1'b1;
        end else if (frame_done) begin
            if (m_armed) m_err = (rx_byte != m_sent);
            m_armed = 1'b0;
        end
        m_apq = addr_phase;
        if (sa_wr_en) m_sa = sa_wr_data;
    endtask

    // One clock with the inputs as set; compare all outputs after the edge.
    task automatic step();
        string mreq, ireq;
        mreq = (frame_done && addr_phase) ? (mask_lsb ? "R3" : "R2") : "R4";
        ireq = irq_on_release ? "R8" : (wake_en ? "R7" : "R6");
        model_step();
        @(posedge clk); #1;
        check(mreq, "match", match, m_match);
        check("R5", "rel_flag", rel_flag, m_rel);
        check(ireq, "irq", irq, m_irq);
        check("R9", "tx_err", tx_err, m_err);
        @(negedge clk);
        sa_wr_en = 0; frame_done = 0; release_det = 0; tx_load = 0;
    endtask

    task automatic idle_inputs();
        sa_wr_en = 0; sa_wr_data = 0; mask_lsb = 0; wake_en = 0; irq_on_release = 0;
        addr_phase = 0; frame_done = 0; release_det = 0; rx_byte = 0;
        tx_load = 0; tx_byte = 0;
    endtask

    // Watchdog.
    initial begin
        #1500000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int r;
        idle_inputs();
        rst_n = 0;
        model_reset();
        r = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1;
        check("R10", "reset match", match, 1'b0);
        check("R10", "reset rel_flag", rel_flag, 1'b0);
        check("R10", "reset irq", irq, 1'b0);
        check("R10", "reset tx_err", tx_err, 1'b0);
        @(negedge clk);
        rst_n = 1;

        // R1: reset address is zero; an address of 0x00 matches.
        addr_phase = 1; frame_done = 1; rx_byte = 8'h00; step();
        check("R1", "zero address match", match, 1'b1);
        // R1: write and compare in the same cycle uses the old address.
        addr_phase = 0; step();
        sa_wr_en = 1; sa_wr_data = 8'h5A; addr_phase = 1; frame_done = 1; rx_byte = 8'h5A; step();
        check("R1", "same-cycle write uses old address", match, 1'b0);
        // R2/R3: exact vs masked compare on an LSB-only difference.
        addr_phase = 0; step();
        addr_phase = 1; frame_done = 1; rx_byte = 8'h5B; step();
        check("R2", "lsb differs unmasked", match, 1'b0);
        addr_phase = 0; step();
        mask_lsb = 1; addr_phase = 1; frame_done = 1; rx_byte = 8'h5B; step();
        check("R3", "lsb differs masked", match, 1'b1);
        // R4: data frame leaves match; a rising phase clears it.
        addr_phase = 0; frame_done = 1; rx_byte = 8'h00; step();
        check("R4", "data frame holds match", match, 1'b1);
        addr_phase = 1; step();
        check("R4", "phase rise clears match", match, 1'b0);
        // R5: release together with a mismatch: set wins.
        release_det = 1; frame_done = 1; rx_byte = 8'hFF; step();
        check("R5", "set beats clear", rel_flag, 1'b1);
        frame_done = 1; rx_byte = 8'hFF; step();
        check("R5", "mismatch clears", rel_flag, 1'b0);
        // R7: wake-up suppresses a mismatch, passes a match.
        wake_en = 1; frame_done = 1; rx_byte = 8'h11; step();
        check("R7", "wake mismatch no irq", irq, 1'b0);
        frame_done = 1; rx_byte = 8'h5A; step();
        check("R7", "wake match irq", irq, 1'b1);
        // R8: release source overrides wake-up.
        irq_on_release = 1; frame_done = 1; rx_byte = 8'h5A; step();
        check("R8", "frame ignored under release source", irq, 1'b0);
        release_det = 1; step();
        check("R8", "release raises irq", irq, 1'b1);
        // R9: load and frame together: load wins, then mismatch sets error.
        tx_load = 1; tx_byte = 8'hC3; frame_done = 1; rx_byte = 8'h00; step();
        check("R9", "load beats frame", tx_err, 1'b0);
        frame_done = 1; rx_byte = 8'hC2; step();
        check("R9", "readback differs", tx_err, 1'b1);
        frame_done = 1; rx_byte = 8'h00; step();
        check("R9", "unarmed frame holds", tx_err, 1'b1);
        irq_on_release = 0; wake_en = 0; mask_lsb = 0; addr_phase = 0; step();

        // Random phase.
        for (int blk = 0; blk < 20; blk++) begin
            mask_lsb       = $urandom_range(0, 1);
            wake_en        = $urandom_range(0, 1);
            irq_on_release = ($urandom_range(0, 3) == 0);
            for (int c = 0; c < 200; c++) begin
                int k;
                if ($urandom_range(0, 5) == 0) addr_phase = ~addr_phase;
                frame_done  = ($urandom_range(0, 2) == 0);
                release_det = ($urandom_range(0, 7) == 0);
                tx_load     = ($urandom_range(0, 9) == 0);
                tx_byte     = 8'($urandom);
                sa_wr_en    = ($urandom_range(0, 49) == 0);
                sa_wr_data  = 8'($urandom);
                k = $urandom_range(0, 3);
                if (k == 0)      rx_byte = m_sa;
                else if (k == 1) rx_byte = m_sa ^ 8'h01;
                else if (k == 2) rx_byte = m_sent;
                else             rx_byte = 8'($urandom);
                step();
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule